// File: doc/BRIEF.md
# SMBus Packet Error Check Receiver

This block keeps the packet error check (PEC) for a receiving SMBus port. It folds every byte delivered by the serial shifter into a running CRC-8. Address bytes count the same as data bytes. The CRC is cleared by each start or repeated start. When software has marked the coming byte as the check byte, that byte is compared against the running CRC instead of being folded in. The block then decides whether the byte gets an ACK or a NACK.

A mismatch always forces a NACK and normally raises a sticky error flag. In slave role the flag stays quiet if the check-byte request came late, meaning it arrived in the cycle after the byte completed. The computed CRC remains readable, so software can still judge the byte itself. Bit timing, the shifter and line driving belong to neighbouring logic.

Top module: `smbus_pec_rx`

## Requirements
- R1: The CRC uses polynomial 0x07 (x^8+x^2+x+1) with initial value 0x00, shifts each byte MSB first, and covers every accepted non-check byte since the last start; `pec_val` shows it one cycle after the byte's decision cycle at the latest (the ASCII string "123456789" gives 0xF4).
- R2: A start pulse clears `pec_val` to 0x00 on the next clock edge and opens a transaction.
- R3: A byte is accepted on a cycle with `byte_vld` high inside a transaction. Its decision appears as a one-cycle `ack_vld` pulse two edges after that cycle. A byte is the check byte if `pec_req` is high in its `byte_vld` cycle (timely) or in the following cycle (late). A non-check byte gets `ack_out` equal to `ack_en`.
- R4: A check byte equal to the running CRC gets `ack_out` = `ack_en` (1 = ACK).
- R5: A check byte that differs from the running CRC gets `ack_out` = 0 whatever `ack_en` is.
- R6: A mismatch sets `pec_err` in master role (`role_slave` = 0), timely or late. In slave role it sets `pec_err` only for a timely request.
- R7: A check byte is not folded into the CRC, so `pec_val` is unchanged by it.
- R8: An `err_clr` pulse clears `pec_err` on the next edge; a new error in the same cycle wins and leaves it set.
- R9: With `en` low, the flag, the CRC, any pending byte and the decision outputs are cleared. Bytes are ignored, and a start is needed after `en` returns.
- R10: After reset `ack_vld`, `ack_out` and `pec_err` are 0 and `pec_val` is 0x00.
- R11: A stop pulse ends the transaction. Bytes after it get no decision and leave `pec_val` unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Peripheral enable; low clears all state |
| start_i | input | 1 | Start or repeated start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus |
| role_slave | input | 1 | 1 = slave role, 0 = master role |
| ack_en | input | 1 | Software ACK enable |
| pec_req | input | 1 | Software marks the byte in flight as the check byte |
| err_clr | input | 1 | Software write-zero pulse for the error flag |
| byte_vld | input | 1 | One-cycle strobe: a byte has been received |
| byte_data | input | 8 | Received byte |
| ack_vld | output | 1 | Decision strobe for the byte received two cycles earlier |
| ack_out | output | 1 | 1 = ACK, 0 = NACK |
| pec_val | output | 8 | Running CRC, readable by software |
| pec_err | output | 1 | Sticky check-byte mismatch flag |

## Verification
The bench aims at a check byte that is wrong while ACK is enabled. A design that only gated the ACK enable would ACK it. It drives late requests in both roles; a design that ignored the role would flag a slave error it should hide, or hide a master error. It checks that a check byte leaves `pec_val` unchanged, so a design that folded it in would show the wrong value. It also sends a clear in the same cycle as a new error and bytes after a stop or while disabled. A design with the wrong priority would drop the error, and one that ignored the bus state would issue decisions or change the CRC.

// File: rtl/smbus_pec_pkg.sv
package smbus_pec_pkg;
  localparam int unsigned PEC_W    = 8;
  localparam logic [7:0]  PEC_POLY = 8'h07;
  localparam logic [7:0]  PEC_INIT = 8'h00;

  typedef enum logic {
    BUS_IDLE = 1'b0,
    BUS_XFER = 1'b1
  } bus_state_e;
endpackage

// File: rtl/pec_crc_step.sv
module pec_crc_step #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic [W-1:0] crc_in,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] crc_out
);
  logic [W-1:0] chain [0:W];

  assign chain[0] = crc_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb           = chain[i][W-1] ^ data_in[W-1-i];
    assign chain[i+1]   = {chain[i][W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  end

  assign crc_out = chain[W];
endmodule

// File: rtl/pec_crc_reg.sv
module pec_crc_reg #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] POLY = 8'h07,
  parameter logic [W-1:0] INIT = 8'h00
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clear,
  input  logic         fold,
  input  logic [W-1:0] data,
  output logic [W-1:0] crc_q
);
  logic [W-1:0] crc_nxt;

  pec_crc_step #(.W(W), .POLY(POLY)) i_step (
    .crc_in  (crc_q),
    .data_in (data),
    .crc_out (crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || !en || clear) crc_q <= INIT;
    else if (fold)           crc_q <= crc_nxt;
  end
endmodule

// File: rtl/pec_capture.sv
module pec_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         accept,
  input  logic         byte_vld,
  input  logic [W-1:0] byte_data,
  input  logic         pec_req,
  output logic         hold_vld,
  output logic [W-1:0] hold_data,
  output logic         hold_ontime
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hold_vld    <= 1'b0;
      hold_data   <= '0;
      hold_ontime <= 1'b0;
    end else begin
      hold_vld <= byte_vld && accept;
      if (byte_vld && accept) begin
        hold_data   <= byte_data;
        hold_ontime <= pec_req;
      end
    end
  end
endmodule

// File: rtl/pec_judge.sv
module pec_judge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hold_vld,
  input  logic is_pec,
  input  logic ontime,
  input  logic match,
  input  logic ack_en,
  input  logic role_slave,
  input  logic err_clr,
  output logic ack_vld,
  output logic ack_out,
  output logic pec_err
);
  logic err_set;

  assign err_set = hold_vld && is_pec && !match && (!role_slave || ontime);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ack_vld <= 1'b0;
      ack_out <= 1'b0;
      pec_err <= 1'b0;
    end else begin
      ack_vld <= hold_vld;
      ack_out <= hold_vld && ack_en && (!is_pec || match);
      if (err_set)      pec_err <= 1'b1;
      else if (err_clr) pec_err <= 1'b0;
    end
  end

  // R8: a clear pulse with no new error empties the flag
  a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
    en && err_clr && !hold_vld |=> !pec_err);
endmodule

// File: rtl/smbus_pec_rx.sv
module smbus_pec_rx
  import smbus_pec_pkg::*;
#(
  parameter int unsigned    W    = PEC_W,
  parameter logic [W-1:0]   POLY = PEC_POLY,
  parameter logic [W-1:0]   INIT = PEC_INIT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         role_slave,
  input  logic         ack_en,
  input  logic         pec_req,
  input  logic         err_clr,
  input  logic         byte_vld,
  input  logic [W-1:0] byte_data,
  output logic         ack_vld,
  output logic         ack_out,
  output logic [W-1:0] pec_val,
  output logic         pec_err
);
  bus_state_e   bus_q;
  logic         accept;
  logic         hold_vld;
  logic [W-1:0] hold_data;
  logic         hold_ontime;
  logic         is_pec;
  logic         match;
  logic         fold;

  always_ff @(posedge clk) begin
    if (rst || !en)   bus_q <= BUS_IDLE;
    else if (start_i) bus_q <= BUS_XFER;
    else if (stop_i)  bus_q <= BUS_IDLE;
  end

  assign accept = (bus_q == BUS_XFER) && !start_i && !stop_i;
  assign is_pec = hold_ontime || pec_req;
  assign match  = (hold_data == pec_val);
  assign fold   = hold_vld && !is_pec;

  pec_capture #(.W(W)) i_cap (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .accept      (accept),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data),
    .pec_req     (pec_req),
    .hold_vld    (hold_vld),
    .hold_data   (hold_data),
    .hold_ontime (hold_ontime)
  );

  pec_crc_reg #(.W(W), .POLY(POLY), .INIT(INIT)) i_crc (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .clear (start_i),
    .fold  (fold),
    .data  (hold_data),
    .crc_q (pec_val)
  );

  pec_judge i_judge (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .hold_vld   (hold_vld),
    .is_pec     (is_pec),
    .ontime     (hold_ontime),
    .match      (match),
    .ack_en     (ack_en),
    .role_slave (role_slave),
    .err_clr    (err_clr),
    .ack_vld    (ack_vld),
    .ack_out    (ack_out),
    .pec_err    (pec_err)
  );

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    en && start_i |=> pec_val == INIT);

  a_r4_ack_gated: assert property (@(posedge clk) disable iff (rst)
    !ack_en |=> !ack_out);

  a_r5_mismatch_nack: assert property (@(posedge clk) disable iff (rst)
    en && hold_vld && is_pec && (hold_data != pec_val) |=> ack_vld && !ack_out);

  a_r6_slave_late_quiet: assert property (@(posedge clk) disable iff (rst)
    en && hold_vld && role_slave && !hold_ontime && !pec_err |=> !pec_err);

  a_r7_pec_freeze: assert property (@(posedge clk) disable iff (rst)
    en && hold_vld && is_pec && !start_i |=> $stable(pec_val));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pec_err && !ack_vld && (pec_val == INIT));

  a_r11_idle_no_decision: assert property (@(posedge clk) disable iff (rst)
    (bus_q == BUS_IDLE) && !start_i |=> !hold_vld);
endmodule

// File: tb/test_smbus_pec_rx.sv
module test_smbus_pec_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1, start_i = 1'b0, stop_i = 1'b0, role_slave = 1'b0;
  logic       ack_en = 1'b1, pec_req = 1'b0, err_clr = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic       ack_vld, ack_out, pec_err;
  logic [7:0] pec_val;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [7:0] ref_crc = 8'h00;
  logic       ref_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_pec_rx i_smbus_pec_rx (
    .clk(clk), .rst(rst), .en(en), .start_i(start_i), .stop_i(stop_i),
    .role_slave(role_slave), .ack_en(ack_en), .pec_req(pec_req),
    .err_clr(err_clr), .byte_vld(byte_vld), .byte_data(byte_data),
    .ack_vld(ack_vld), .ack_out(ack_out), .pec_val(pec_val), .pec_err(pec_err)
  );

  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ 8'h07;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    ref_crc = 8'h00;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  // sends one byte and checks its decision two edges later
  task automatic send(input logic [7:0] d, input bit ontime, input bit late,
                      input bit clr_at_dec, input string req);
    bit pec = ontime || late;
    bit match = (d == ref_crc);
    bit exp_ack = ack_en && (!pec || match);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = d; pec_req = ontime;
    @(negedge clk);
    check({req, " R3 no early decision"}, {31'd0, ack_vld}, 32'd0);
    byte_vld = 1'b0; pec_req = ontime || late; err_clr = clr_at_dec;
    @(negedge clk);
    pec_req = 1'b0; err_clr = 1'b0;
    if (pec && !match && (!role_slave || ontime)) ref_err = 1'b1;
    else if (clr_at_dec) ref_err = 1'b0;
    if (!pec) ref_crc = crc_ref(ref_crc, d);
    check({req, " R3 ack_vld"}, {31'd0, ack_vld}, 32'd1);
    check({req, pec ? (match ? " R4 ack" : " R5 nack") : " R3 data ack"},
          {31'd0, ack_out}, {31'd0, exp_ack});
    check({req, " R6 pec_err"}, {31'd0, pec_err}, {31'd0, ref_err});
    check({req, pec ? " R7 pec_val" : " R1 pec_val"}, {24'd0, pec_val}, {24'd0, ref_crc});
  endtask

  task automatic clear_flag();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    ref_err = 1'b0;
    check("R8 clear", {31'd0, pec_err}, 32'd0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] msg [9];
    logic [31:0] rv;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 ack_vld", {31'd0, ack_vld}, 32'd0);
    check("R10 ack_out", {31'd0, ack_out}, 32'd0);
    check("R10 pec_err", {31'd0, pec_err}, 32'd0);
    check("R10 pec_val", {24'd0, pec_val}, 32'd0);

    // R1 known vector "123456789" -> 0xF4
    do_start();
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    for (int i = 0; i < 9; i++) send(msg[i], 1'b0, 1'b0, 1'b0, "R1 vec");
    check("R1 known value", {24'd0, pec_val}, 32'hF4);
    send(8'hF4, 1'b1, 1'b0, 1'b0, "R4 good pec");
    // R5: bad pec with ack enabled, master timely
    send(8'hF5, 1'b1, 1'b0, 1'b0, "R5 bad pec");
    clear_flag();
    do_stop();

    // R6 slave late mismatch: no flag, still NACK
    role_slave = 1'b1;
    do_start();
    send(8'hA0, 1'b0, 1'b0, 1'b0, "R6 slave");
    send(8'h00, 1'b0, 1'b1, 1'b0, "R6 slave late");
    send(8'h00, 1'b1, 1'b0, 1'b0, "R6 slave timely");
    clear_flag();
    role_slave = 1'b0;
    send(8'h00, 1'b0, 1'b1, 1'b0, "R6 master late");
    // R8 clear and new error in same cycle: error wins
    send(8'h01, 1'b1, 1'b0, 1'b1, "R8 set wins");
    check("R8 set wins flag", {31'd0, pec_err}, 32'd1);
    clear_flag();

    // R2 start clears
    send(8'h5A, 1'b0, 1'b0, 1'b0, "R2 pre");
    do_start();
    check("R2 start clears", {24'd0, pec_val}, 32'd0);

    // R11 bytes after stop are ignored
    send(8'h77, 1'b0, 1'b0, 1'b0, "R11 pre");
    do_stop();
    @(negedge clk) begin byte_vld = 1'b1; byte_data = 8'h3C; end
    @(negedge clk) byte_vld = 1'b0;
    @(negedge clk);
    check("R11 no decision", {31'd0, ack_vld}, 32'd0);
    check("R11 crc kept", {24'd0, pec_val}, {24'd0, ref_crc});

    // R9 disable clears and ignores bytes
    do_start();
    send(8'h12, 1'b0, 1'b0, 1'b0, "R9 pre");
    send(8'h00, 1'b1, 1'b0, 1'b0, "R9 err");
    @(negedge clk) begin en = 1'b0; byte_vld = 1'b1; byte_data = 8'h99; end
    @(negedge clk) byte_vld = 1'b0;
    @(negedge clk);
    check("R9 flag cleared", {31'd0, pec_err}, 32'd0);
    check("R9 crc cleared", {24'd0, pec_val}, 32'd0);
    check("R9 no decision", {31'd0, ack_vld}, 32'd0);
    en = 1'b1; ref_err = 1'b0; ref_crc = 8'h00;
    @(negedge clk) begin byte_vld = 1'b1; byte_data = 8'h44; end
    @(negedge clk) byte_vld = 1'b0;
    @(negedge clk);
    check("R9 needs start", {31'd0, ack_vld}, 32'd0);

    // random transactions
    for (int t = 0; t < 60; t++) begin
      rv = $urandom; role_slave = rv[0]; ack_en = rv[1];
      do_start();
      for (int b = 0; b < 1 + int'(rv[4:2] % 3'd5); b++) begin
        logic [31:0] dv = $urandom;
        send(dv[7:0], 1'b0, 1'b0, 1'b0, "R1 rnd data");
      end
      if (rv[6:5] != 2'b00) begin
        logic [7:0] p = ref_crc;
        if (rv[7]) p = p ^ (8'h01 << rv[10:8]);
        send(p, !rv[11], rv[11], rv[14:12] == 3'd0, "R5 rnd pec");
      end
      if (rv[17:15] == 3'd0) clear_flag();
      do_stop();
    end
    finish_run();
  end
endmodule